// File: doc/BRIEF.md
# Single-Cycle RISC-V Subset Processor

This block is a 32-bit processor that completes one instruction per clock cycle. In that cycle it fetches, decodes, reads registers, runs the ALU, accesses data memory and writes back. It executes a small integer subset: word load, word store, branch-if-equal, and the register-to-register operations add, sub, and, or, xor and slt. Instructions outside this subset are not supported.

Decoding happens in two stages. The first stage maps the opcode to a set of datapath strobes and a 2-bit operation class. The second stage turns that class into an exact ALU code, using funct3 and, for the add/sub pair, opcode bit 5 together with funct7 bit 5. The instruction store and the data memory are both read without a clock. While reset is held, the testbench fills either memory through a preload port. After that it watches the program counter, the write-back value and the ALU flags through debug taps.

Top module: `rv_core`

## Requirements
- R1: While `rstN` is low, the program counter reads 0 and every register reads 0. Once `rstN` is high, the program counter takes its next value on each rising clock edge.
- R2: For any instruction that is not a taken branch, the next program counter is the current one plus 4.
- R3: For a branch (opcode 1100011, funct3 000), if the two source registers are equal, the next program counter is the current one plus the sign-extended B-format offset, which may be negative. Otherwise it is the current one plus 4. During the branch, `wbTap` shows the difference rs1 minus rs2.
- R4: A load (opcode 0000011, funct3 010) writes the data memory word selected by bits [7:2] of rs1 plus the sign-extended I-format offset into rd. During the load, `wbTap` shows that word.
- R5: Register x0 always reads as zero. A write that targets x0 is dropped.
- R6: A store (opcode 0100011, funct3 010) writes rs2 into the word at rs1 plus the S-format offset. It writes no register. During the store, `wbTap` shows the computed byte address. A load in the next cycle from the same address returns the stored value.
- R7: An R-type instruction (opcode 0110011) writes rd with one of the following, selected by funct3: 000 gives add, or subtract when funct7 bit 5 is 1. 111 gives and, 110 gives or, 100 gives xor.
- R8: R-type funct3 010 (slt) writes 1 when the sign bit of rs1 minus rs2 is set, and 0 otherwise. The upper 31 bits are zero.
- R9: An R-type instruction whose funct3 is not listed in R7 or R8 executes as add.
- R10: `flagsTap` is {negative, zero, carry, overflow} in bits 3 down to 0. Negative is result bit 31 and zero means a zero result. Carry is the adder carry-out for add, subtract and slt, and 0 otherwise. Overflow is set for add, subtract or slt when both operands entering the adder share a sign and the sum's sign differs from it.
- R11: On a rising edge with `loadEn` high, `loadData` is written to word `loadAddr` of the instruction store when `loadToData` is 0, or of the data memory when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| loadEn | input | 1 | Preload write strobe |
| loadToData | input | 1 | Preload target: 0 instruction store, 1 data memory |
| loadAddr | input | 6 | Preload word index (log2 of memory depth) |
| loadData | input | 32 | Preload word |
| pcTap | output | 32 | Current program counter |
| wbTap | output | 32 | Value on the write-back mux this cycle |
| flagsTap | output | 4 | ALU flags {negative, zero, carry, overflow} |

## Verification
For a branch-if-equal, the subtraction that produces the zero flag also chooses the next program counter in the same cycle. The bench therefore runs one branch with equal operands and one with unequal operands, plus a backward branch. It judges each by the program counter one edge later and by the flag tap while the branch is current. A store followed directly by a load from the same word tests the memory write at the edge against the combinational read in the next cycle. A write to x0 followed directly by a read of x0 checks that the dropped write never reaches the read port.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;
  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW = $clog2(REG_COUNT);

  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_RTYPE  = 7'b0110011;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } opClassT;

  typedef enum logic [2:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_AND = 3'b010,
    ALU_OR  = 3'b011,
    ALU_SLT = 3'b101,
    ALU_XOR = 3'b111
  } aluCtlT;

  typedef enum logic [1:0] {
    IMM_I = 2'b00,
    IMM_S = 2'b01,
    IMM_B = 2'b10
  } immSelT;

  typedef struct packed {
    logic   regWrite;
    immSelT immSel;
    logic   aluSrcImm;
    logic   memWrite;
    logic   resultMem;
    logic   branch;
    aluCtlT aluCtl;
  } ctrlT;

  typedef struct packed {
    logic negative;
    logic zero;
    logic carry;
    logic overflow;
  } aluFlagsT;
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import rv_core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrlT            ctl
);
  logic [6:0] op;
  logic [2:0] funct3;
  logic       f7Bit5;
  opClassT    opClass;

  assign op     = instr[6:0];
  assign funct3 = instr[14:12];
  assign f7Bit5 = instr[30];

  // First stage: opcode to strobes and operation class
  always_comb begin
    ctl.regWrite  = 1'b0;
    ctl.immSel    = IMM_I;
    ctl.aluSrcImm = 1'b0;
    ctl.memWrite  = 1'b0;
    ctl.resultMem = 1'b0;
    ctl.branch    = 1'b0;
    opClass       = CLS_ADD;
    case (op)
      OP_LOAD: begin
        ctl.regWrite  = 1'b1;
        ctl.aluSrcImm = 1'b1;
        ctl.resultMem = 1'b1;
      end
      OP_STORE: begin
        ctl.immSel    = IMM_S;
        ctl.aluSrcImm = 1'b1;
        ctl.memWrite  = 1'b1;
      end
      OP_BRANCH: begin
        ctl.immSel = IMM_B;
        ctl.branch = 1'b1;
        opClass    = CLS_SUB;
      end
      OP_RTYPE: begin
        ctl.regWrite = 1'b1;
        opClass      = CLS_FUNCT;
      end
      default: ;
    endcase
  end

  // Second stage: class plus funct fields to ALU code
  always_comb begin
    ctl.aluCtl = ALU_ADD;
    case (opClass)
      CLS_SUB: ctl.aluCtl = ALU_SUB;
      CLS_FUNCT: begin
        case (funct3)
          3'b000:  ctl.aluCtl = ({op[5], f7Bit5} == 2'b11) ? ALU_SUB : ALU_ADD;
          3'b010:  ctl.aluCtl = ALU_SLT;
          3'b110:  ctl.aluCtl = ALU_OR;
          3'b111:  ctl.aluCtl = ALU_AND;
          3'b100:  ctl.aluCtl = ALU_XOR;
          default: ctl.aluCtl = ALU_ADD;
        endcase
      end
      default: ctl.aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import rv_core_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aluCtlT          aluCtl,
  output logic [XLEN-1:0] result,
  output aluFlagsT        flags
);
  logic [XLEN-1:0] bEff;
  logic [XLEN:0]   sumFull;
  logic [XLEN-1:0] sum;
  logic            invB;
  logic            logicOp;

  assign invB    = aluCtl[0];
  assign logicOp = aluCtl[1];
  assign bEff    = invB ? ~b : b;
  assign sumFull = {1'b0, a} + {1'b0, bEff} + {{XLEN{1'b0}}, invB};
  assign sum     = sumFull[XLEN-1:0];

  always_comb begin
    case (aluCtl)
      ALU_ADD, ALU_SUB: result = sum;
      ALU_AND:          result = a & b;
      ALU_OR:           result = a | b;
      ALU_XOR:          result = a ^ b;
      ALU_SLT:          result = {{(XLEN-1){1'b0}}, sum[XLEN-1]};
      default:          result = '0;
    endcase
  end

  assign flags.negative = result[XLEN-1];
  assign flags.zero     = (result == '0);
  assign flags.carry    = ~logicOp & sumFull[XLEN];
  assign flags.overflow = (sum[XLEN-1] ^ a[XLEN-1])
                        & ~(invB ^ b[XLEN-1] ^ a[XLEN-1])
                        & ~logicOp;
endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import rv_core_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlT             ctl,
  output logic [XLEN-1:0]  instr,
  input  logic             loadEn,
  input  logic             loadToData,
  input  logic [IDX_W-1:0] loadAddr,
  input  logic [XLEN-1:0]  loadData,
  output logic [XLEN-1:0]  pcTap,
  output logic [XLEN-1:0]  wbTap,
  output aluFlagsT         flagsTap
);
  logic [XLEN-1:0] pc, pcNext, immExt, srcA, srcB, aluB, aluRes, memRd, wbVal;
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [XLEN-1:0] regs [REG_COUNT];
  logic [REG_AW-1:0] rs1Addr, rs2Addr, rdAddr;
  aluFlagsT flags;
  logic takeBranch;

  always_ff @(posedge clk) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr] <= loadData;
  end
  assign instr = imem[pc[IDX_W+1:2]];

  assign rs1Addr = instr[19:15];
  assign rs2Addr = instr[24:20];
  assign rdAddr  = instr[11:7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (ctl.regWrite && rdAddr != '0) begin
      regs[rdAddr] <= wbVal;
    end
  end
  assign srcA = regs[rs1Addr];
  assign srcB = regs[rs2Addr];

  always_comb begin
    case (ctl.immSel)
      IMM_I:   immExt = {{(XLEN-12){instr[31]}}, instr[31:20]};
      IMM_S:   immExt = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      IMM_B:   immExt = {{(XLEN-13){instr[31]}}, instr[31], instr[7],
                         instr[30:25], instr[11:8], 1'b0};
      default: immExt = '0;
    endcase
  end

  assign aluB = ctl.aluSrcImm ? immExt : srcB;

  core_alu u_alu (
    .a      (srcA),
    .b      (aluB),
    .aluCtl (ctl.aluCtl),
    .result (aluRes),
    .flags  (flags)
  );

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)      dmem[loadAddr] <= loadData;
    else if (rstN && ctl.memWrite) dmem[aluRes[IDX_W+1:2]] <= srcB;
  end
  assign memRd = dmem[aluRes[IDX_W+1:2]];
  assign wbVal = ctl.resultMem ? memRd : aluRes;

  assign takeBranch = ctl.branch & flags.zero;
  assign pcNext     = takeBranch ? pc + immExt : pc + XLEN'(4);

  assign pcTap    = pc;
  assign wbTap    = wbVal;
  assign flagsTap = flags;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !takeBranch |=> pc == $past(pc) + XLEN'(4));

  assert_branch_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    takeBranch |=> pc == $past(pc) + $past(immExt));

  assert_x0_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWrite |-> (!ctl.regWrite && !ctl.resultMem && ctl.aluSrcImm));

  assert_slt_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.aluCtl == ALU_SLT |-> aluRes[XLEN-1:1] == '0);

  assert_equal_sub_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aluCtl == ALU_SUB && srcA == aluB) |-> (flags.zero && flags.carry && !flags.overflow));
endmodule

// File: rtl/rv_core.sv
module rv_core
  import rv_core_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             loadToData,
  input  logic [IDX_W-1:0] loadAddr,
  input  logic [XLEN-1:0]  loadData,
  output logic [XLEN-1:0]  pcTap,
  output logic [XLEN-1:0]  wbTap,
  output logic [3:0]       flagsTap
);
  ctrlT            ctl;
  logic [XLEN-1:0] instr;
  aluFlagsT        flags;

  core_ctrl u_ctrl (
    .instr (instr),
    .ctl   (ctl)
  );

  core_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .instr      (instr),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .pcTap      (pcTap),
    .wbTap      (wbTap),
    .flagsTap   (flags)
  );

  assign flagsTap = flags;
endmodule

// File: tb/rv_core_test.sv
`timescale 1ns/1ps
module rv_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pcTap, wbTap;
  logic [3:0]  flagsTap;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] prog [27];

  always #2 clk = ~clk;

  rv_core uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData),
    .pcTap(pcTap), .wbTap(wbTap), .flagsTap(flagsTap)
  );

  function automatic logic [31:0] encR(input logic [6:0] f7, input int rs2, input int rs1,
                                       input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] encLw(input logic [11:0] imm, input int rs1, input int rd);
    return {imm, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] encSw(input logic [11:0] imm, input int rs2, input int rs1);
    return {imm[11:5], 5'(rs2), 5'(rs1), 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encBeq(input logic [12:0] imm, input int rs2, input int rs1);
    return {imm[12], imm[10:5], 5'(rs2), 5'(rs1), 3'b000, imm[4:1], imm[11], 7'b1100011};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // check pc and write-back of the current instruction, optionally flags, then advance
  task automatic step(input logic [31:0] ePc, input logic [31:0] eWb, input string what,
                      input bit doFlags = 0, input logic [3:0] eFlags = '0);
    check(pcTap, ePc, {what, " pc"});
    check(wbTap, eWb, {what, " wb"});
    if (doFlags) check({28'b0, flagsTap}, {28'b0, eFlags}, {what, " flags"});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadWord(input bit toData, input int idx, input logic [31:0] w);
    loadEn = 1'b1;
    loadToData = toData;
    loadAddr = 6'(idx);
    loadData = w;
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic testResetAndPreload;  // R11 preload, R1 reset state
    prog[0]  = encLw(12'd0, 0, 1);
    prog[1]  = encLw(12'd4, 0, 2);
    prog[2]  = encR(7'b0000000, 2, 1, 3'b000, 3);
    prog[3]  = encR(7'b0100000, 2, 1, 3'b000, 4);
    prog[4]  = encR(7'b0100000, 1, 2, 3'b000, 5);
    prog[5]  = encR(7'b0000000, 2, 1, 3'b111, 6);
    prog[6]  = encR(7'b0000000, 2, 1, 3'b110, 7);
    prog[7]  = encR(7'b0000000, 2, 1, 3'b100, 8);
    prog[8]  = encR(7'b0000000, 1, 2, 3'b010, 9);
    prog[9]  = encR(7'b0000000, 2, 1, 3'b010, 10);
    prog[10] = encLw(12'd8, 0, 11);
    prog[11] = encLw(12'd12, 0, 12);
    prog[12] = encR(7'b0000000, 1, 11, 3'b000, 13);
    prog[13] = encR(7'b0000000, 1, 12, 3'b000, 14);
    prog[14] = encR(7'b0000000, 1, 12, 3'b010, 19);
    prog[15] = encR(7'b0000000, 2, 1, 3'b001, 20);
    prog[16] = encR(7'b0000000, 2, 1, 3'b000, 0);
    prog[17] = encR(7'b0000000, 1, 0, 3'b000, 15);
    prog[18] = encSw(12'd20, 3, 0);
    prog[19] = encLw(12'd20, 0, 16);
    prog[20] = encBeq(13'd8, 2, 1);
    prog[21] = encBeq(13'd12, 16, 3);
    prog[22] = encR(7'b0000000, 1, 1, 3'b000, 17);
    prog[23] = encBeq(13'd8, 0, 0);
    prog[24] = encBeq(13'h1FF8, 0, 0);
    prog[25] = encR(7'b0000000, 0, 17, 3'b000, 18);
    prog[26] = encR(7'b0100000, 17, 18, 3'b000, 21);
    for (int i = 0; i < 27; i++) loadWord(1'b0, i, prog[i]);
    loadWord(1'b1, 0, 32'd7);
    loadWord(1'b1, 1, 32'd5);
    loadWord(1'b1, 2, 32'h7FFF_FFFF);
    loadWord(1'b1, 3, 32'hFFFF_FFFF);
    check(pcTap, 32'd0, "R1 pc held at zero in reset");
    check(wbTap, 32'd7, "R11 preloaded data word visible");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testLoads;  // R4, R2
    step(32'd0, 32'd7, "R4 lw x1");
    step(32'd4, 32'd5, "R4 lw x2 R2");
  endtask

  task automatic testArith;  // R7, R10
    step(32'd8,  32'd12,          "R7 add", 1, 4'b0000);
    step(32'd12, 32'd2,           "R7 sub", 1, 4'b0010);
    step(32'd16, 32'hFFFF_FFFE,   "R7 sub negative R10", 1, 4'b1000);
    step(32'd20, 32'd5,           "R7 and", 1, 4'b0000);
    step(32'd24, 32'd7,           "R7 or");
    step(32'd28, 32'd2,           "R7 xor");
  endtask

  task automatic testSlt;  // R8
    step(32'd32, 32'd1, "R8 slt 5<7");
    step(32'd36, 32'd0, "R8 slt 7<5", 1, 4'b0110);
  endtask

  task automatic testFlags;  // R10, R8, R9
    step(32'd40, 32'h7FFF_FFFF, "R4 lw max positive");
    step(32'd44, 32'hFFFF_FFFF, "R4 lw all ones");
    step(32'd48, 32'h8000_0006, "R10 add overflow", 1, 4'b1001);
    step(32'd52, 32'd6,         "R10 add carry", 1, 4'b0010);
    step(32'd56, 32'd1,         "R8 slt signed -1<7");
    step(32'd60, 32'd12,        "R9 unlisted funct3 as add");
  endtask

  task automatic testX0;  // R5
    step(32'd64, 32'd12, "R5 write to x0");
    step(32'd68, 32'd7,  "R5 x0 reads zero after write");
  endtask

  task automatic testStore;  // R6
    step(32'd72, 32'd20, "R6 sw address on wb");
    step(32'd76, 32'd12, "R6 load after store");
  endtask

  task automatic testBranch;  // R3
    step(32'd80,  32'd2,  "R3 beq not taken", 1, 4'b0010);
    step(32'd84,  32'd0,  "R3 beq taken", 1, 4'b0110);
    step(32'd96,  32'd0,  "R3 backward beq");
    step(32'd88,  32'd14, "R3 landed on backward target");
    step(32'd92,  32'd0,  "R3 forward beq x0");
    step(32'd100, 32'd14, "R3 landed on forward target");
    check(pcTap, 32'd104, "R2 sequential after branch");
    check(wbTap, 32'd0,   "R7 sub to zero");
  endtask

  initial begin
    @(negedge clk);
    testResetAndPreload();
    testLoads();
    testArith();
    testSlt();
    testFlags();
    testX0();
    testStore();
    testBranch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule